// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block puts a 256-byte configuration array behind two byte-wide bus ports. The index port selects an entry and the data port reads or writes it. A host sets the window's enable through its own configuration-byte write. While that enable is clear the window ignores every write and reads back all-ones. Data-port writes pass through a fixed per-entry protection map. Most entries cannot be written at all. Two entries take a write only when the byte equals one fixed key value. All other entries take any byte.

Each access is one byte wide and lasts one strobe cycle. Read data is registered: the byte from a read strobe appears on the read-data output after the next clock edge and stays there until the next read. The enable register, the index register and the array entries all update on the same clock edge. So any access in a given cycle sees the enable, index and entry values held before that edge.

Top module: `cfg_window`

## Requirements
- R1: A write strobe with `bus_addr`=0 (index port) while enabled loads the index register with `bus_wdata`; the following read returns the entry at that index.
- R2: A data-port write (`bus_addr`=1) while enabled stores `bus_wdata` into the entry at the current index when that entry is freely writable: 0xe0, 0xe1, 0xe2, 0xe3, 0xe6, 0xee, 0xef, 0xf0, 0xf1, 0xf2, 0xf4, 0xf6, 0xf8, 0xfc.
- R3: Data-port writes to any index below 0xe0, or to 0xe4, 0xe5, 0xe9..0xed, 0xf3, 0xf5, 0xf7, 0xf9..0xfb, 0xfd..0xff, leave the entry unchanged.
- R4: Index 0xe7 takes a data-port write only when the byte is 0xfe, and index 0xe8 only when it is 0xbe; any other byte leaves the entry unchanged.
- R5: A read strobe on either port while enabled places the entry at the current index on `bus_rdata` after the next clock edge; `bus_rdata` holds until the next read strobe.
- R6: After reset the index is 0x00 and the entries read 0xe0=0x3c, 0xe2=0x03, 0xe3=0xfc, 0xe6=0xde, 0xe7=0xfe, 0xe8=0xbe, with every other entry 0x00.
- R7: The window is disabled after reset; a strobe on `cfg_wr` sets the enable to bit 1 of `cfg_data`, and other bits of `cfg_data` have no effect.
- R8: While disabled, index and data writes change nothing, a read strobe returns 0xff, and `bus_rdata` is 0xff from reset until the first read.
- R9: An access in the same cycle as a `cfg_wr` strobe is judged by the enable value held before that strobe.
- R10: A read and a data-port write in the same cycle return the entry value from before the write; the written value is seen by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| cfg_wr | input | 1 | Host configuration-byte write strobe |
| cfg_data | input | 8 | Host configuration byte; bit 1 is the window enable |

## Verification
Two kinds of event can land in the same cycle. One is a host enable write alongside a bus access. The other is a read alongside a data-port write. The bench provokes both on purpose, with directed cycles that set the enable while writing the index and clear it while writing data, and with a random stream that raises several strobes at once. Each result is compared with a bench model that applies the read first, the write next and the enable change last, all using the state held before the edge.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  localparam int CW_DW = 8;
  localparam int CW_AW = 8;
  localparam int CW_DEPTH = 1 << CW_AW;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_sel_e;

  // Value an entry takes at reset.
  function automatic logic [CW_DW-1:0] entry_reset(input int unsigned i);
    case (i)
      32'he0:  return 8'h3c;
      32'he2:  return 8'h03;
      32'he3:  return 8'hfc;
      32'he6:  return 8'hde;
      32'he7:  return 8'hfe;
      32'he8:  return 8'hbe;
      default: return '0;
    endcase
  endfunction

  // Entries that never accept a data-port write.
  function automatic logic entry_locked(input logic [CW_AW-1:0] i);
    if (i < 8'he0) return 1'b1;
    case (i)
      8'he4, 8'he5,
      8'he9, 8'hea, 8'heb, 8'hec, 8'hed,
      8'hf3, 8'hf5, 8'hf7,
      8'hf9, 8'hfa, 8'hfb,
      8'hfd, 8'hfe, 8'hff: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  // Entries that accept a single key value only.
  function automatic logic entry_keyed(input logic [CW_AW-1:0] i);
    return (i == 8'he7) || (i == 8'he8);
  endfunction

  function automatic logic [CW_DW-1:0] entry_key(input logic [CW_AW-1:0] i);
    return (i == 8'he7) ? 8'hfe : 8'hbe;
  endfunction

endpackage

// File: rtl/cfg_enable.sv
module cfg_enable #(
  parameter int DW     = 8,
  parameter int EN_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_data,
  output logic          en_q
);
  logic en_d;
  logic unused_host_bits;

  assign unused_host_bits = ^{host_data[DW-1:EN_BIT+1], host_data[EN_BIT-1:0]};

  always_comb begin
    en_d = en_q;
    if (host_wr) en_d = host_data[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/cfg_wprot.sv
module cfg_wprot
  import cfg_window_pkg::*;
#(
  parameter int DW = CW_DW,
  parameter int AW = CW_AW
) (
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] data,
  output logic          accept
);
  logic locked;
  logic keyed;
  logic key_hit;

  always_comb begin
    locked  = entry_locked(idx);
    keyed   = entry_keyed(idx);
    key_hit = (data == entry_key(idx));
    accept  = !locked && (!keyed || key_hit);
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_window_pkg::*;
#(
  parameter int DW = CW_DW,
  parameter int AW = CW_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] bank [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [DW-1:0] RST_VAL = entry_reset(g);
    logic          hit;
    logic [DW-1:0] q;

    assign hit = we && (addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (hit) q <= wdata;
    end

    assign bank[g] = q;
  end

  assign rdata = bank[addr];
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int DW     = CW_DW,
  parameter int AW     = CW_AW,
  parameter int EN_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_data
);
  logic          win_en;
  logic [AW-1:0] idx_q, idx_d;
  logic          wr_ok;
  logic          data_we;
  logic [DW-1:0] sel_entry;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          idx_we;

  cfg_enable #(.DW(DW), .EN_BIT(EN_BIT)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (cfg_wr),
    .host_data (cfg_data),
    .en_q      (win_en)
  );

  cfg_wprot #(.DW(DW), .AW(AW)) u_prot (
    .idx    (idx_q),
    .data   (bus_wdata),
    .accept (wr_ok)
  );

  assign idx_we  = win_en && bus_wr && (bus_addr == PORT_INDEX);
  assign data_we = win_en && bus_wr && (bus_addr == PORT_DATA) && wr_ok;

  cfg_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (data_we),
    .addr  (idx_q),
    .wdata (bus_wdata),
    .rdata (sel_entry)
  );

  always_comb begin
    idx_d = idx_q;
    if (idx_we) idx_d = bus_wdata[AW-1:0];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = win_en ? sel_entry : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '1;
    end else begin
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       cfg_wr,
  input logic [7:0] cfg_data,
  input logic       win_en,
  input logic [7:0] idx_q,
  input logic [7:0] sel_entry
);
  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && win_en) |=> (idx_q == $past(bus_wdata)));

  // R3
  low_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && win_en && idx_q < 8'he0) |=> (sel_entry == $past(sel_entry)));

  // R4
  key_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && win_en &&
     ((idx_q == 8'he7 && bus_wdata != 8'hfe) || (idx_q == 8'he8 && bus_wdata != 8'hbe)))
    |=> (sel_entry == $past(sel_entry)));

  // R5
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && win_en) |=> (bus_rdata == $past(sel_entry)));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (win_en == $past(cfg_data[1])));

  // R8
  dis_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !win_en) |=> (bus_rdata == 8'hff));

  // R9
  old_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !win_en) |=> (idx_q == $past(idx_q) && sel_entry == $past(sel_entry)));
endmodule

bind cfg_window cfg_window_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cfg_wr    (cfg_wr),
  .cfg_data  (cfg_data),
  .win_en    (win_en),
  .idx_q     (idx_q),
  .sel_entry (sel_entry)
);

// File: tb/cfg_window_bench.sv
`timescale 1ns/1ps
module cfg_window_bench;
  logic       clk;
  logic       rst_n;
  logic       bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cfg_wr;
  logic [7:0] cfg_data;

  int checks;
  int failures;

  logic [7:0] ref_mem [256];
  logic [7:0] ref_idx;
  logic       ref_en;

  cfg_window u_cfg_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_wr    (cfg_wr),
    .cfg_data  (cfg_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] exp_reset(input int i);
    if (i == 'he0) return 8'h3c;
    if (i == 'he2) return 8'h03;
    if (i == 'he3) return 8'hfc;
    if (i == 'he6) return 8'hde;
    if (i == 'he7) return 8'hfe;
    if (i == 'he8) return 8'hbe;
    return 8'h00;
  endfunction

  function automatic bit may_write(input logic [7:0] i, input logic [7:0] d);
    if (i == 8'he7) return d == 8'hfe;
    if (i == 8'he8) return d == 8'hbe;
    case (i)
      8'he0, 8'he1, 8'he2, 8'he3, 8'he6, 8'hee, 8'hef, 8'hf0,
      8'hf1, 8'hf2, 8'hf4, 8'hf6, 8'hf8, 8'hfc: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // One bus cycle; the model applies read, then write, then enable, all from old state.
  task automatic cyc(input string tag, input bit wr, input bit rd, input bit a,
                     input logic [7:0] d, input bit hw, input logic [7:0] hd);
    logic [7:0] exp;
    exp = ref_en ? ref_mem[ref_idx] : 8'hff;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    cfg_wr = hw; cfg_data = hd;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; cfg_wr = 1'b0;
    if (wr && ref_en) begin
      if (!a) ref_idx = d;
      else if (may_write(ref_idx, d)) ref_mem[ref_idx] = d;
    end
    if (hw) ref_en = hd[1];
    if (rd) check(tag, bus_rdata, exp);
  endtask

  task automatic set_idx(input logic [7:0] i);
    cyc("R1", 1'b1, 1'b0, 1'b0, i, 1'b0, 8'h00);
  endtask

  task automatic rd_data(input string tag);
    cyc(tag, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic wr_data(input logic [7:0] d);
    cyc("R2", 1'b1, 1'b0, 1'b1, d, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    checks = 0; failures = 0;
    bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    cfg_wr = 1'b0; cfg_data = '0;
    for (int i = 0; i < 256; i++) ref_mem[i] = exp_reset(i);
    ref_idx = 8'h00; ref_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 read-data register resets to all-ones
    check("R8", bus_rdata, 8'hff);
    // R7 disabled after reset: reads give 0xff
    cyc("R7", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    // R8 writes while disabled have no effect
    cyc("R8", 1'b1, 1'b0, 1'b0, 8'he0, 1'b0, 8'h00);
    // R7 only bit 1 of the host byte counts
    cyc("R7", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hfd);
    cyc("R7", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    cyc("R7", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h02);
    // R6 index still 0 and entry 0 reads 0
    cyc("R6", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
    // R6 reset values over the upper range
    for (int i = 'hd8; i < 256; i++) begin
      set_idx(8'(i));
      rd_data("R6");
    end
    // R2 free entry takes any byte
    set_idx(8'hf4); wr_data(8'h5a); rd_data("R2");
    // R3 locked entries keep their value
    set_idx(8'h10); wr_data(8'h77); rd_data("R3");
    set_idx(8'hff); wr_data(8'h33); rd_data("R3");
    set_idx(8'he5); wr_data(8'h11); rd_data("R3");
    // R4 keyed entries
    set_idx(8'he7); wr_data(8'h12); rd_data("R4"); wr_data(8'hfe); rd_data("R4");
    set_idx(8'he8); wr_data(8'hbf); rd_data("R4"); wr_data(8'hbe); rd_data("R4");
    // R10 read and write in one cycle
    set_idx(8'he1);
    cyc("R10", 1'b1, 1'b1, 1'b1, 8'ha5, 1'b0, 8'h00);
    rd_data("R10");
    // R9 clear enable while writing: write still lands
    cyc("R9", 1'b1, 1'b0, 1'b1, 8'hc3, 1'b1, 8'h00);
    cyc("R9", 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00);
    // R9 set enable while writing index: index not loaded
    cyc("R9", 1'b1, 1'b0, 1'b0, 8'he0, 1'b1, 8'h02);
    rd_data("R9");
    // R1 index-port read returns the selected entry
    set_idx(8'he3);
    cyc("R1", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);

    // R5 random mixture
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [7:0] v;
      r = $urandom % 100;
      v = ($urandom % 4 != 0) ? 8'(8'he0 + ($urandom % 32)) : 8'($urandom);
      if (r < 25)      cyc("R5", 1'b1, $urandom % 4 == 0, 1'b0, v, 1'b0, 8'h00);
      else if (r < 55) cyc("R5", 1'b1, $urandom % 3 == 0, 1'b1,
                           ($urandom % 3 == 0) ? v : 8'($urandom), 1'b0, 8'h00);
      else if (r < 95) cyc("R5", 1'b0, 1'b1, 1'($urandom), 8'h00, 1'b0, 8'h00);
      else             cyc("R5", 1'($urandom), 1'b1, 1'($urandom), v, 1'b1,
                           ($urandom % 4 == 0) ? 8'h00 : 8'hff);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule